// File: doc/BRIEF.md
# Load/Store Alignment and Extension Unit

This unit connects a register-based execution core to a 64-bit, byte-addressed data memory port. For each request the core presents an 8-bit memory opcode, a base register value, a signed 16-bit displacement and the register that holds the store source. The unit decodes the access width and direction from the opcode. It adds the sign-extended displacement to the base to form the effective address, with wraparound modulo 2^64, and checks that the access is naturally aligned.

An aligned access becomes a single memory transaction. The unit presents the 8-byte word address, drives a one-cycle request strobe, and then waits for the memory to answer. Stores place the low bytes of the source register onto the addressed byte lanes and raise a byte mask over those lanes. Loads take the answering word, shift the addressed lane down to bit 0 and zero-extend the result to 64 bits. A misaligned access of 2, 4 or 8 bytes never reaches memory. The unit raises a one-cycle trap instead.

Top module: `lsu_align_unit`

## Requirements
- R1: Opcodes 0x71, 0x69, 0x61 and 0x79 are loads of 1, 2, 4 and 8 bytes. Opcodes 0x73, 0x6b, 0x63 and 0x7b are stores of 1, 2, 4 and 8 bytes. `memWrite` is 1 for a store and 0 for a load while `memValid` is high.
- R2: A request whose opcode is none of the eight above is ignored. No strobe, no done and no trap follow it, and `busy` stays low.
- R3: The effective address EA is `reqBase` plus `reqOffset` sign-extended to 64 bits, modulo 2^64. `memAddr` equals EA with bits [2:0] cleared, and EA[2:0] selects the starting byte lane (lane k is bits [8k+7:8k], little-endian).
- R4: A load sets `loadResult` to the N bytes of `memRdata` that start at lane EA[2:0], placed at bit 0. All bits above 8N are zero.
- R5: For a store of N bytes, `memByteEn` bit k is 1 exactly for lanes EA[2:0] through EA[2:0]+N-1. For a load, `memByteEn` is all zero.
- R6: For a store, `memWdata` equals `reqStoreData` shifted left by 8*EA[2:0] bits and truncated to 64 bits, so that the low N source bytes sit on the enabled lanes.
- R7: A 2-, 4- or 8-byte access whose EA is not a multiple of its size raises `trap` for exactly one cycle, the cycle after acceptance. No `memValid` and no `done` follow it. A 1-byte access never traps.
- R8: A request is accepted on a rising edge where `reqValid` is high and `busy` is low. `memValid` is high for exactly the one cycle after acceptance, and `busy` is high from that cycle through the `done` or `trap` cycle.
- R9: `done` is high for one cycle, following the first rising edge from the strobe cycle onward at which `memReady` is high. `loadResult` updates in that cycle and holds until the next load completes.
- R10: `reqValid` while `busy` is high has no effect. No second strobe or completion follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Core presents a request this cycle |
| reqOpcode | input | 8 | Memory opcode |
| reqBase | input | 64 | Base register value |
| reqOffset | input | 16 | Signed displacement |
| reqStoreData | input | 64 | Store source register |
| busy | output | 1 | Transaction or trap in progress |
| memValid | output | 1 | One-cycle memory request strobe |
| memWrite | output | 1 | Request is a store |
| memAddr | output | 64 | Word address, low three bits zero |
| memByteEn | output | 8 | Store lane mask |
| memWdata | output | 64 | Lane-shifted store data |
| memReady | input | 1 | Memory has completed the request |
| memRdata | input | 64 | Memory read word |
| done | output | 1 | One-cycle completion pulse |
| loadResult | output | 64 | Zero-extended load value |
| trap | output | 1 | One-cycle misalignment trap |

## Verification
The unit accepts a request on edge E0, and one register stage separates that edge from every memory-side output. `memValid`, `memAddr`, `memByteEn`, `memWdata` and `memWrite` are therefore checked in the cycle after E0, and so is `trap` for a misaligned access. `done` and the new `loadResult` are due one cycle after the edge that sees `memReady`, so the bench raises ready after a random delay of zero to three cycles and checks one cycle after that edge. All sampling happens on the falling edge, and the bench also checks that the cycle after each pulse is quiet: no repeated strobe, trap or completion, and `busy` is released.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DBL  = 2'd3
  } accSize_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_FINISH,
    ST_FAULT
  } lsuState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic captureReq;
    logic captureRsp;
  } lsuStrobes_t;

endpackage

// File: rtl/lsu_datapath.sv
module lsu_datapath
  import lsu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 64,
  parameter int OFF_W  = 16,
  parameter int OP_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  lsuStrobes_t       strobes,
  input  logic [OP_W-1:0]   reqOpcode,
  input  logic [ADDR_W-1:0] reqBase,
  input  logic [OFF_W-1:0]  reqOffset,
  input  logic [DATA_W-1:0] reqStoreData,
  input  logic [DATA_W-1:0] memRdata,
  output logic              isMem,
  output logic              misaligned,
  output logic              memWrite,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W/8-1:0] memByteEn,
  output logic [DATA_W-1:0] memWdata,
  output logic [DATA_W-1:0] loadResult
);

  localparam int LANES  = DATA_W / 8;
  localparam int LANE_W = $clog2(LANES);
  localparam int CNT_W  = LANE_W + 1;

  // opcode decode
  logic     isStoreDec;
  accSize_t sizeDec;

  always_comb begin
    isMem      = 1'b1;
    isStoreDec = 1'b0;
    sizeDec    = SZ_BYTE;
    unique case (reqOpcode)
      8'h71: sizeDec = SZ_BYTE;
      8'h69: sizeDec = SZ_HALF;
      8'h61: sizeDec = SZ_WORD;
      8'h79: sizeDec = SZ_DBL;
      8'h73: begin sizeDec = SZ_BYTE; isStoreDec = 1'b1; end
      8'h6b: begin sizeDec = SZ_HALF; isStoreDec = 1'b1; end
      8'h63: begin sizeDec = SZ_WORD; isStoreDec = 1'b1; end
      8'h7b: begin sizeDec = SZ_DBL;  isStoreDec = 1'b1; end
      default: isMem = 1'b0;
    endcase
  end

  // effective address and alignment check
  logic [ADDR_W-1:0] effAddr;
  logic [LANE_W-1:0] alignMask;

  assign effAddr    = reqBase + {{(ADDR_W-OFF_W){reqOffset[OFF_W-1]}}, reqOffset};
  assign alignMask  = LANE_W'((CNT_W'(1) << sizeDec) - CNT_W'(1));
  assign misaligned = (effAddr[LANE_W-1:0] & alignMask) != '0;

  // captured request
  logic [ADDR_W-1:0] eaQ;
  accSize_t          sizeQ;
  logic              isStoreQ;
  logic [DATA_W-1:0] storeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eaQ      <= '0;
      sizeQ    <= SZ_BYTE;
      isStoreQ <= 1'b0;
      storeQ   <= '0;
    end else if (strobes.captureReq) begin
      eaQ      <= effAddr;
      sizeQ    <= sizeDec;
      isStoreQ <= isStoreDec;
      storeQ   <= reqStoreData;
    end
  end

  logic [LANE_W-1:0] laneQ;
  logic [CNT_W-1:0]  bytesQ;

  assign laneQ    = eaQ[LANE_W-1:0];
  assign bytesQ   = CNT_W'(1) << sizeQ;
  assign memAddr  = {eaQ[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
  assign memWrite = isStoreQ;
  assign memWdata = storeQ << {laneQ, 3'b000};

  // lane mask and zero-extension, one slice per byte lane
  logic [DATA_W-1:0] rdShifted;
  logic [DATA_W-1:0] loadNext;

  assign rdShifted = memRdata >> {laneQ, 3'b000};

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign memByteEn[k] = isStoreQ
                          && (CNT_W'(k) >= {1'b0, laneQ})
                          && (CNT_W'(k) <  ({1'b0, laneQ} + bytesQ));
    assign loadNext[8*k +: 8] = (CNT_W'(k) < bytesQ) ? rdShifted[8*k +: 8] : 8'h00;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loadResult <= '0;
    end else if (strobes.captureRsp && !isStoreQ) begin
      loadResult <= loadNext;
    end
  end

  // R4: a byte load leaves only the low byte nonzero
  assert_byte_zext_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.captureRsp && !isStoreQ && sizeQ == SZ_BYTE) |=> (loadResult[DATA_W-1:8] == '0));

  // R5: a store enables as many lanes as its size; a load enables none
  assert_store_lanes_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.captureRsp |-> (memWrite ? ($countones(memByteEn) == int'(bytesQ)) : (memByteEn == '0)));

  // R9: the result is stable unless a load response was captured
  assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.captureRsp && !isStoreQ) |=> $stable(loadResult));

endmodule

// File: rtl/lsu_ctrl.sv
module lsu_ctrl
  import lsu_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        isMem,
  input  logic        misaligned,
  input  logic        memReady,
  output lsuStrobes_t strobes,
  output logic        busy,
  output logic        memValid,
  output logic        done,
  output logic        trap
);

  lsuState_t state, stateNext;

  always_comb begin
    stateNext          = state;
    strobes.captureReq = 1'b0;
    strobes.captureRsp = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid && isMem) begin
          strobes.captureReq = 1'b1;
          stateNext = misaligned ? ST_FAULT : ST_ISSUE;
        end
      end
      ST_ISSUE, ST_WAIT: begin
        if (memReady) begin
          strobes.captureRsp = 1'b1;
          stateNext = ST_FINISH;
        end else begin
          stateNext = ST_WAIT;
        end
      end
      ST_FINISH: stateNext = ST_IDLE;
      ST_FAULT:  stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign memValid = (state == ST_ISSUE);
  assign done     = (state == ST_FINISH);
  assign trap     = (state == ST_FAULT);
  assign busy     = (state != ST_IDLE);

  // R8: the request strobe lasts a single cycle
  assert_strobe_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    memValid |=> !memValid);

  // R9: completion only follows a sampled ready
  assert_done_after_ready_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(memReady));

  // R7: a trap follows a misaligned memory request seen while idle
  assert_trap_cause_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(trap) |-> $past(reqValid && isMem && misaligned));

  // R7: trap, strobe and completion are mutually exclusive
  assert_pulse_excl_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({trap, memValid, done}));

endmodule

// File: rtl/lsu_align_unit.sv
module lsu_align_unit
  import lsu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 64,
  parameter int OFF_W  = 16,
  parameter int OP_W   = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic [OP_W-1:0]     reqOpcode,
  input  logic [ADDR_W-1:0]   reqBase,
  input  logic [OFF_W-1:0]    reqOffset,
  input  logic [DATA_W-1:0]   reqStoreData,
  output logic                busy,
  output logic                memValid,
  output logic                memWrite,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [DATA_W/8-1:0] memByteEn,
  output logic [DATA_W-1:0]   memWdata,
  input  logic                memReady,
  input  logic [DATA_W-1:0]   memRdata,
  output logic                done,
  output logic [DATA_W-1:0]   loadResult,
  output logic                trap
);

  lsuStrobes_t strobes;
  logic        isMem;
  logic        misaligned;

  lsu_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .isMem      (isMem),
    .misaligned (misaligned),
    .memReady   (memReady),
    .strobes    (strobes),
    .busy       (busy),
    .memValid   (memValid),
    .done       (done),
    .trap       (trap)
  );

  lsu_datapath #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .OFF_W  (OFF_W),
    .OP_W   (OP_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .reqOpcode    (reqOpcode),
    .reqBase      (reqBase),
    .reqOffset    (reqOffset),
    .reqStoreData (reqStoreData),
    .memRdata     (memRdata),
    .isMem        (isMem),
    .misaligned   (misaligned),
    .memWrite     (memWrite),
    .memAddr      (memAddr),
    .memByteEn    (memByteEn),
    .memWdata     (memWdata),
    .loadResult   (loadResult)
  );

endmodule

// File: tb/lsu_align_unit_tb.sv
`timescale 1ns/1ps
module lsu_align_unit_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [7:0]  reqOpcode = '0;
  logic [63:0] reqBase = '0;
  logic [15:0] reqOffset = '0;
  logic [63:0] reqStoreData = '0;
  logic        busy, memValid, memWrite, done, trap;
  logic [63:0] memAddr, memWdata, loadResult;
  logic [7:0]  memByteEn;
  logic        memReady = 1'b0;
  logic [63:0] memRdata = '0;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;
  logic [63:0] lastLoad = '0;

  always #10 clk = ~clk;

  lsu_align_unit u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOpcode(reqOpcode),
    .reqBase(reqBase), .reqOffset(reqOffset), .reqStoreData(reqStoreData),
    .busy(busy), .memValid(memValid), .memWrite(memWrite), .memAddr(memAddr),
    .memByteEn(memByteEn), .memWdata(memWdata), .memReady(memReady),
    .memRdata(memRdata), .done(done), .loadResult(loadResult), .trap(trap)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] opOf(input int idx);
    case (idx)
      0: return 8'h71; 1: return 8'h69; 2: return 8'h61; 3: return 8'h79;
      4: return 8'h73; 5: return 8'h6b; 6: return 8'h63; default: return 8'h7b;
    endcase
  endfunction

  function automatic int sizeOf(input logic [7:0] op);
    case (op)
      8'h71, 8'h73: return 1;
      8'h69, 8'h6b: return 2;
      8'h61, 8'h63: return 4;
      8'h79, 8'h7b: return 8;
      default:      return 0;
    endcase
  endfunction

  function automatic bit isStoreOp(input logic [7:0] op);
    return (op == 8'h73) || (op == 8'h6b) || (op == 8'h63) || (op == 8'h7b);
  endfunction

  function automatic logic [63:0] eaOf(input logic [63:0] b, input logic [15:0] o);
    return b + {{48{o[15]}}, o};
  endfunction

  function automatic logic [7:0] expMask(input int n, input int lane);
    logic [7:0] m = '0;
    for (int k = 0; k < 8; k++) if (k >= lane && k < lane + n) m[k] = 1'b1;
    return m;
  endfunction

  function automatic logic [63:0] expLoad(input logic [63:0] word, input int n, input int lane);
    logic [63:0] r = '0;
    for (int j = 0; j < n; j++) r[8*j +: 8] = word[8*(lane+j) +: 8];
    return r;
  endfunction

  // one full access; delay = cycles of ready withheld after the strobe cycle
  task automatic runAccess(input logic [7:0] op, input logic [63:0] b, input logic [15:0] o,
                           input logic [63:0] sd, input int delay, input logic [63:0] rd,
                           input bit pokeBusy);
    logic [63:0] ea = eaOf(b, o);
    int n = sizeOf(op);
    int lane = int'(ea[2:0]);
    bit bad = (n > 1) && ((ea % n) != 0);
    @(negedge clk);
    reqValid = 1'b1; reqOpcode = op; reqBase = b; reqOffset = o; reqStoreData = sd;
    @(negedge clk);
    reqValid = 1'b0;
    if (n == 0) begin
      check(!busy && !memValid && !trap && !done, "R2 ignored opcode", {60'd0, busy, memValid, trap, done}, 64'd0);
      return;
    end
    if (bad) begin
      check(trap == 1'b1 && !memValid, "R7 trap pulse", {62'd0, trap, memValid}, 64'd2);
      check(busy == 1'b1, "R8 busy during trap", {63'd0, busy}, 64'd1);
      @(negedge clk);
      check(!trap && !busy && !memValid && !done, "R7 trap ends, no access", {60'd0, trap, busy, memValid, done}, 64'd0);
      return;
    end
    check(memValid == 1'b1 && busy, "R8 strobe after accept", {62'd0, memValid, busy}, 64'd3);
    check(memWrite == isStoreOp(op), "R1 direction", {63'd0, memWrite}, {63'd0, isStoreOp(op)});
    check(memAddr == {ea[63:3], 3'b000}, "R3 word address", memAddr, {ea[63:3], 3'b000});
    if (isStoreOp(op)) begin
      check(memByteEn == expMask(n, lane), "R5 store lanes", {56'd0, memByteEn}, {56'd0, expMask(n, lane)});
      check(memWdata == (sd << (8*lane)), "R6 store data", memWdata, sd << (8*lane));
    end else begin
      check(memByteEn == 8'h00, "R5 load mask zero", {56'd0, memByteEn}, 64'd0);
    end
    memRdata = rd;
    if (pokeBusy) begin
      reqValid = 1'b1; reqOpcode = 8'h79; reqBase = 64'h0; reqOffset = 16'h0;
    end
    for (int d = 0; d < delay; d++) begin
      @(negedge clk);
      reqValid = 1'b0;
      check(!memValid && !done && busy, "R9 waiting for ready", {61'd0, memValid, done, busy}, 64'd1);
    end
    memReady = 1'b1;
    @(negedge clk);
    memReady = 1'b0; reqValid = 1'b0;
    check(done == 1'b1 && busy, "R9 done after ready", {62'd0, done, busy}, 64'd3);
    if (!isStoreOp(op)) lastLoad = expLoad(rd, n, lane);
    check(loadResult == lastLoad, isStoreOp(op) ? "R9 result held over store" : "R4 zero-extended load",
          loadResult, lastLoad);
    @(negedge clk);
    check(!done && !busy && !memValid, "R10 no second access", {61'd0, done, busy, memValid}, 64'd0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nFails++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'h5eed1234);
    repeat (3) @(negedge clk);
    check(!busy && !memValid && !done && !trap && loadResult == 64'd0, "R8 reset state",
          {60'd0, busy, memValid, done, trap}, 64'd0);
    rstN = 1'b1;

    // directed corners
    runAccess(8'h79, 64'h1000, 16'h0008, 64'd0, 0, 64'h8877665544332211, 1'b0);        // R1 R4 dword load
    runAccess(8'h71, 64'h1000, 16'h0007, 64'd0, 1, 64'h8877665544332211, 1'b0);        // R4 top lane byte
    runAccess(8'h69, 64'h0000000000002000, 16'hFFFA, 64'd0, 2, 64'hA1B2C3D4E5F60718, 1'b0); // R3 negative offset
    runAccess(8'h61, 64'hFFFFFFFFFFFFFFFC, 16'h0008, 64'd0, 0, 64'hDEADBEEFCAFEF00D, 1'b0); // R3 wraparound
    runAccess(8'h6b, 64'h3000, 16'h0006, 64'h1122334455667788, 0, 64'd0, 1'b0);        // R5 R6 half store
    runAccess(8'h73, 64'h3000, 16'h0003, 64'h00000000000000AB, 3, 64'd0, 1'b1);        // R6 R10 byte store
    runAccess(8'h63, 64'h3002, 16'h0000, 64'h0, 0, 64'd0, 1'b0);                       // R7 misaligned word
    runAccess(8'h79, 64'h3004, 16'h0000, 64'h0, 0, 64'd0, 1'b0);                       // R7 misaligned dword
    runAccess(8'h69, 64'h3001, 16'h0000, 64'h0, 0, 64'd0, 1'b0);                       // R7 misaligned half
    runAccess(8'h7b, 64'h3000, 16'h7FF8, 64'hFEDCBA9876543210, 1, 64'd0, 1'b0);        // R5 full store
    runAccess(8'h95, 64'h3000, 16'h0000, 64'h0, 0, 64'd0, 1'b0);                       // R2 non-memory opcode
    runAccess(8'h70, 64'h3000, 16'h0000, 64'h0, 0, 64'd0, 1'b0);                       // R2 near miss

    // constrained random
    for (int i = 0; i < 400; i++) begin
      logic [7:0]  op = opOf(int'($urandom % 8));
      logic [63:0] b  = {$urandom, $urandom};
      logic [15:0] o  = 16'($urandom);
      int n = sizeOf(op);
      if (($urandom % 4) != 0) begin
        logic [63:0] ea = eaOf(b, o);
        b = b - (ea % n);
      end
      if (($urandom % 16) == 0) op = 8'($urandom);
      runAccess(op, b, o, {$urandom, $urandom}, int'($urandom % 4), {$urandom, $urandom},
                ($urandom % 5) == 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule